// File: doc/BRIEF.md
# Packed String Lane Unit

This block works on a short text string packed into one register doubleword. The doubleword holds eight character lanes of six bits each. Lane 0 carries the first character, and the all-zero code in a lane marks a null. With each valid input the block takes a two-bit opcode and runs one of four operations:

- **Truncate** clears everything after the first null.
- **Length** counts the characters in front of the first null.
- **Left-align** packs the string against lane 0.
- **Right-align** packs the string against lane 7.

For the two alignment operations, the string is the first run of non-null characters that follows any leading nulls. Every lane the string does not fill becomes null.

The unit is a single pipeline stage. Lane scanning, the alignment shifts and the result selection are all combinational. The result word, the length value and an output valid strobe are registered, and they appear on the clock edge after the input strobe. Between valid inputs the outputs hold their last values, so a consumer can read the result at any later time.

Top module: `str_lane_unit`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a clock edge, `out_valid`, `out_data` and `out_len` are all cleared to zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R3: A cycle with `in_valid` low leaves `out_data` and `out_len` unchanged at the next edge.
- R4: For every opcode, `out_len` is the index of the lowest lane holding 0. It lies in the range 0 to 8.
- R5: Opcode 0 (truncate) returns the input with every lane above the first null set to 0. The first null lane and all lanes below it are kept.
- R6: When no lane holds 0, truncate returns the input unchanged and `out_len` is 8.
- R7: Opcode 2 (left-align) places the characters of the string in lanes 0 upward, in their original order. All remaining lanes are 0.
- R8: Opcode 3 (right-align) places the characters of the string so that the last one sits in lane 7, in their original order. All lower lanes are 0.
- R9: Leading null lanes are skipped when the alignment opcodes find the string. An all-null input aligns to all zeros.
- R10: Opcode 1 (length) returns the length count zero-extended in `out_data`, with bit 0 of lane 0 as the least significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request strobe |
| in_op | input | 2 | Opcode: 0 truncate, 1 length, 2 left-align, 3 right-align |
| in_data | input | 48 | Packed string, lane i in bits 6i+5 down to 6i |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_data | output | 48 | Result doubleword |
| out_len | output | 4 | Characters before the first null |

## Verification
Several properties are checked by assertions on every cycle:

- the one-cycle strobe relation;
- the holding of outputs on idle cycles;
- the bound on the length;
- for truncate, that every lane at or above the reported length is null;
- after left-align, a non-empty result has a character in lane 0;
- after right-align, a non-empty result has a character in lane 7.

The assertions cannot show that characters keep their order and values through the alignment shifts. Nor can they show that leading nulls are skipped or that the length value is correct. Only the bench's directed and random strings, compared against its behavioural model every cycle, show those.

// File: rtl/str_lane_pkg.sv
package str_lane_pkg;
  typedef enum logic [1:0] {
    OP_TRUNC = 2'd0,
    OP_LEN   = 2'd1,
    OP_LEFT  = 2'd2,
    OP_RIGHT = 2'd3
  } str_op_e;
endpackage

// File: rtl/str_lane_scan.sv
// Finds the first null lane, the first non-null lane, and the length of the
// character run that starts at that first non-null lane.
module str_lane_scan #(
  parameter int LANES = 8,
  parameter int CW    = 6,
  localparam int DW   = LANES * CW,
  localparam int IW   = $clog2(LANES + 1)
) (
  input  logic [DW-1:0] data,
  output logic [IW-1:0] first_null,
  output logic [IW-1:0] run_start,
  output logic [IW-1:0] run_len
);
  logic [LANES-1:0] is_null;

  for (genvar g = 0; g < LANES; g++) begin : g_flag
    assign is_null[g] = (data[g*CW +: CW] == '0);
  end

  always_comb begin
    int fn;
    int rs;
    int re;
    bit seen;
    fn   = LANES;
    rs   = LANES;
    re   = LANES;
    seen = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (is_null[i]) fn = i;
      if (!is_null[i]) rs = i;
    end
    for (int i = 0; i < LANES; i++) begin
      if (!seen && i >= rs && is_null[i]) begin
        re   = i;
        seen = 1'b1;
      end
    end
    first_null = IW'(fn);
    run_start  = IW'(rs);
    run_len    = IW'(re - rs);
  end
endmodule

// File: rtl/str_lane_align.sv
// Packs a run of lanes toward lane 0 (RIGHT=0) or toward the top lane (RIGHT=1).
module str_lane_align #(
  parameter int LANES = 8,
  parameter int CW    = 6,
  parameter bit RIGHT = 1'b0,
  localparam int DW   = LANES * CW,
  localparam int IW   = $clog2(LANES + 1)
) (
  input  logic [DW-1:0] data,
  input  logic [IW-1:0] start,
  input  logic [IW-1:0] len,
  output logic [DW-1:0] aligned
);
  if (RIGHT) begin : g_right
    always_comb begin
      int base;
      int src;
      aligned = '0;
      base = LANES - int'(len);
      for (int i = 0; i < LANES; i++) begin
        src = int'(start) + i - base;
        if (i >= base && src >= 0 && src < LANES)
          aligned[i*CW +: CW] = data[src*CW +: CW];
      end
    end
  end else begin : g_left
    always_comb begin
      int src;
      aligned = '0;
      for (int i = 0; i < LANES; i++) begin
        src = int'(start) + i;
        if (i < int'(len) && src < LANES)
          aligned[i*CW +: CW] = data[src*CW +: CW];
      end
    end
  end
endmodule

// File: rtl/str_lane_unit.sv
module str_lane_unit
  import str_lane_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CW    = 6,
  localparam int DW   = LANES * CW,
  localparam int IW   = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [IW-1:0] out_len
);
  logic [IW-1:0] first_null;
  logic [IW-1:0] run_start;
  logic [IW-1:0] run_len;
  logic [DW-1:0] trunc_word;
  logic [DW-1:0] left_word;
  logic [DW-1:0] right_word;
  logic [DW-1:0] result;

  str_lane_scan #(.LANES(LANES), .CW(CW)) u_scan (
    .data       (in_data),
    .first_null (first_null),
    .run_start  (run_start),
    .run_len    (run_len)
  );

  str_lane_align #(.LANES(LANES), .CW(CW), .RIGHT(1'b0)) u_left (
    .data    (in_data),
    .start   (run_start),
    .len     (run_len),
    .aligned (left_word)
  );

  str_lane_align #(.LANES(LANES), .CW(CW), .RIGHT(1'b1)) u_right (
    .data    (in_data),
    .start   (run_start),
    .len     (run_len),
    .aligned (right_word)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_trunc
    assign trunc_word[g*CW +: CW] = (g > int'(first_null)) ? '0 : in_data[g*CW +: CW];
  end

  always_comb begin
    unique case (str_op_e'(in_op))
      OP_TRUNC: result = trunc_word;
      OP_LEN:   result = {{(DW-IW){1'b0}}, first_null};
      OP_LEFT:  result = left_word;
      OP_RIGHT: result = right_word;
      default:  result = trunc_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_len   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= result;
        out_len  <= first_null;
      end
    end
  end

  function automatic bit lanes_null_from(input logic [DW-1:0] w, input logic [IW-1:0] from);
    bit ok;
    ok = 1'b1;
    for (int i = 0; i < LANES; i++)
      if (i >= int'(from) && w[i*CW +: CW] != '0) ok = 1'b0;
    return ok;
  endfunction

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);                                            // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);                                          // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable(out_len)));             // R3
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(out_len) <= LANES);                                            // R4
  AST_TRUNC_TAIL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_TRUNC) |=> lanes_null_from(out_data, out_len)); // R5
  AST_LEFT_HEAD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_LEFT) |=> (out_data == '0 || out_data[CW-1:0] != '0)); // R7
  AST_RIGHT_TOP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_RIGHT) |=> (out_data == '0 || out_data[DW-1 -: CW] != '0)); // R8
endmodule

// File: tb/str_lane_unit_test.sv
`timescale 1ns/1ps
module str_lane_unit_test;
  localparam int LANES = 8;
  localparam int CW    = 6;
  localparam int DW    = LANES * CW;
  localparam int IW    = $clog2(LANES + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    in_op = 2'd0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic [IW-1:0] out_len;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic          exp_valid = 1'b0;
  logic [DW-1:0] exp_data = '0;
  logic [IW-1:0] exp_len = '0;
  string         data_req = "R1";

  always #2.5 clk = ~clk;

  str_lane_unit #(.LANES(LANES), .CW(CW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_len(out_len)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model: plain lane arrays and a queue of characters.
  function automatic void model(input logic [1:0] op, input logic [DW-1:0] d,
                                output logic [DW-1:0] r, output logic [IW-1:0] l);
    int ln[LANES];
    int first;
    int pos;
    int q[$];
    first = LANES;
    for (int i = 0; i < LANES; i++) ln[i] = int'(d[i*CW +: CW]);
    for (int i = LANES - 1; i >= 0; i--) if (ln[i] == 0) first = i;
    l = IW'(first);
    r = '0;
    pos = 0;
    while (pos < LANES && ln[pos] == 0) pos++;
    while (pos < LANES && ln[pos] != 0) begin q.push_back(ln[pos]); pos++; end
    case (op)
      2'd0: for (int i = 0; i < LANES; i++) if (i <= first) r[i*CW +: CW] = CW'(ln[i]);
      2'd1: r = DW'(first);
      2'd2: for (int k = 0; k < q.size(); k++) r[k*CW +: CW] = CW'(q[k]);
      default: for (int k = 0; k < q.size(); k++)
                 r[(LANES - q.size() + k)*CW +: CW] = CW'(q[k]);
    endcase
  endfunction

  function automatic logic [DW-1:0] pack(input int c0, c1, c2, c3, c4, c5, c6, c7);
    int v[LANES];
    logic [DW-1:0] w;
    v = '{c0, c1, c2, c3, c4, c5, c6, c7};
    for (int i = 0; i < LANES; i++) w[i*CW +: CW] = CW'(v[i]);
    return w;
  endfunction

  function automatic string op_req(input logic [1:0] op, input logic [DW-1:0] d);
    bit has_null;
    has_null = 1'b0;
    for (int i = 0; i < LANES; i++) if (d[i*CW +: CW] == '0) has_null = 1'b1;
    case (op)
      2'd0: return has_null ? "R5" : "R6";
      2'd1: return "R10";
      2'd2: return (d[CW-1:0] == '0) ? "R9" : "R7";
      default: return (d[CW-1:0] == '0) ? "R9" : "R8";
    endcase
  endfunction

  // Compares the outputs with the model, then drives the next request.
  task automatic step(input logic v, input logic [1:0] op, input logic [DW-1:0] d);
    @(negedge clk);
    chk("R2", DW'(out_valid), DW'(exp_valid));
    chk(data_req, out_data, exp_data);
    chk("R4", DW'(out_len), DW'(exp_len));
    in_valid = v;
    in_op    = op;
    in_data  = d;
    exp_valid = v;
    if (v) begin
      model(op, d, exp_data, exp_len);
      data_req = op_req(op, d);
    end else begin
      data_req = "R3";
    end
  endtask

  initial begin
    logic [DW-1:0] w;
    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    in_data  = pack(1, 2, 3, 4, 5, 6, 7, 8);
    @(negedge clk);
    chk("R1", DW'(out_valid), '0);
    chk("R1", out_data, '0);
    chk("R1", DW'(out_len), '0);
    in_valid = 1'b0;
    rst = 1'b0;

    w = pack(1, 2, 3, 4, 5, 0, 7, 8);
    step(1, 2'd0, w);
    step(1, 2'd1, w);
    step(1, 2'd2, w);
    step(1, 2'd3, w);
    step(0, 2'd1, pack(9, 9, 9, 9, 9, 9, 9, 9));
    step(0, 2'd0, '0);
    step(1, 2'd0, pack(1, 2, 3, 4, 5, 6, 7, 8));
    step(1, 2'd1, pack(1, 2, 3, 4, 5, 6, 7, 8));
    step(1, 2'd3, pack(1, 2, 3, 4, 5, 6, 7, 8));
    step(1, 2'd2, pack(0, 0, 11, 12, 0, 13, 0, 14));
    step(1, 2'd3, pack(0, 0, 11, 12, 0, 13, 0, 14));
    step(1, 2'd2, '0);
    step(1, 2'd3, '0);
    step(1, 2'd1, pack(0, 3, 3, 3, 3, 3, 3, 3));
    step(1, 2'd0, pack(0, 3, 3, 3, 3, 3, 3, 3));
    step(1, 2'd3, pack(0, 0, 0, 0, 0, 0, 0, 63));
    step(1, 2'd2, pack(0, 0, 0, 0, 0, 0, 0, 63));
    step(1, 2'd1, pack(63, 63, 63, 63, 63, 63, 63, 0));

    for (int n = 0; n < 600; n++) begin
      for (int i = 0; i < LANES; i++)
        w[i*CW +: CW] = ($urandom_range(0, 2) == 0) ? '0 : CW'($urandom_range(1, 63));
      step(($urandom_range(0, 4) != 0), 2'($urandom_range(0, 3)), w);
    end
    step(0, 2'd0, '0);
    step(0, 2'd0, '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule